// File: doc/BRIEF.md
# Memory-Backed Singly Linked List Controller

This block keeps one singly linked list inside a small single-port memory that has one cycle of read latency. Every memory word holds four things: a used flag, a tail flag, a data payload and the address of the next entry. The tail flag ends the list, so the pointer of the tail word carries no meaning. A head register, cleared to address 0 at reset, records where the list starts. An empty flag records whether the list holds any entries.

A host issues one command at a time on a valid-qualified command port. Four operations are available:

- Load appends a value at the next sequential address.
- Walk streams the payloads out in list order.
- Remove unlinks an entry, either at the head or after a given predecessor address.
- Add places a new value, either at the head or after a given predecessor address.

Remove and add are fixed read-modify-write sequences. Add looks for the lowest unused slot by reading the slots one after another.

A command is taken only while `busy` is low. `busy` stays high until the cycle in which `done` pulses. `err` pulses together with `done` when a command is refused.

Top module: `ll_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `outValid` are low and the list is empty. A walk on an empty list emits no word and finishes with `done` high and `err` low.
- R2: A run of load commands writes value k at address k, counting from 0. The load with `cmdLast`=1 ends the run, makes address 0 the head and makes that value the tail. The list then reads back in load order.
- R3: A walk emits one `outData` word per list entry, in list order, each with `outValid` high. `outLast` is high only with the tail's word, and `done` follows the final word.
- R4: Removing after predecessor address P (`cmdHead`=0) unlinks P's successor. All other entries keep their order.
- R5: When the removed entry was the tail, its predecessor becomes the tail.
- R6: Removing with `cmdHead`=1 drops the first entry, and the next entry becomes the head. Removing the only entry leaves the list empty.
- R7: A remove is refused with `err` pulsing together with `done`, and the list unchanged, in three cases: the list is empty and `cmdHead`=1; P is unused; or P is the tail.
- R8: Adding after predecessor P places the new value directly after P. Adding after the tail makes the new value the tail. Adding after an unused P is refused with `err`.
- R9: Adding with `cmdHead`=1 puts the new value first. Adding to an empty list gives a one-entry list whose word has `outLast` high.
- R10: An added entry is stored at the lowest unused address, so that address can then serve as a predecessor P.
- R11: When every slot is in use, an add is refused with `err` and the list is unchanged.
- R12: `busy` rises in the cycle after a command is accepted. Commands presented while `busy` is high are ignored.
- R13: Every accepted command ends with exactly one one-cycle `done` pulse. `err` is never high without `done`.

Command encoding on `cmdOp`: 0 = load, 1 = walk, 2 = remove, 3 = add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command present; taken when `busy` is low |
| cmdOp | input | 2 | 0 load, 1 walk, 2 remove, 3 add |
| cmdHead | input | 1 | Remove or add works at the head instead of after `cmdPtr` |
| cmdLast | input | 1 | Marks the final value of a load run |
| cmdPtr | input | ADDR_W | Predecessor address for remove and add |
| cmdData | input | DATA_W | Payload for load and add |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| err | output | 1 | One-cycle pulse, together with `done`, when a command is refused |
| outValid | output | 1 | `outData` carries a walked entry |
| outLast | output | 1 | The current walked entry is the tail |
| outData | output | DATA_W | Payload of the walked entry |

## Verification
The bench aims at the points where pointer upkeep goes wrong.

- Removing the tail: a design that skips moving the tail flag walks past the new tail into a freed slot and returns extra words.
- Removing at the head: a design that misses the head update still streams the dropped value.
- Adding after the tail: a design that does not clear the old tail flag stops the walk one word early.
- Slot reuse: the bench uses a freshly filled slot as a predecessor. A scan that does not return the lowest unused address then removes the wrong entry.
- Refusals: the bench fills every slot, and it removes after the tail and after an unused address. In each case it expects `err` and an unchanged list; a missing guard would corrupt the links.
- Busy window: a command sent during a walk must leave no trace on the list.

// File: rtl/ll_pkg.sv
package ll_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_WALK = 2'd1,
    OP_DEL  = 2'd2,
    OP_INS  = 2'd3
  } llOp_t;

  // memory address source
  typedef enum logic [2:0] {
    A_PRED, A_VIC, A_SCAN, A_FREE, A_WALK, A_LOAD
  } llAddrSel_t;

  // memory write word source
  typedef enum logic [2:0] {
    W_LOAD, W_KILL, W_NEW, W_UNLINK, W_LINK
  } llWrSel_t;

  typedef struct packed {
    logic       memRd;
    logic       memWr;
    llAddrSel_t addrSel;
    llWrSel_t   wrSel;
    logic       capCmd;
    logic       capPred;
    logic       capVic;
    logic       capFree;
    logic       scanClr;
    logic       scanInc;
    logic       walkStart;
    logic       walkStep;
    logic       emit;
    logic       loadStep;
    logic       headPop;
    logic       headPush;
  } llStrobe_t;

  typedef struct packed {
    logic listEmpty;
    logic rdValid;
    logic rdLast;
    logic scanLast;
  } llStat_t;

endpackage

// File: rtl/ll_dpath.sv
module ll_dpath
  import ll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  llStrobe_t         st,
  input  logic              cmdHead,
  input  logic              cmdLast,
  input  logic [ADDR_W-1:0] cmdPtr,
  input  logic [DATA_W-1:0] cmdData,
  output llStat_t           stat,
  output logic              outValid,
  output logic              outLast,
  output logic [DATA_W-1:0] outData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + ADDR_W + 2;
  localparam int VB     = WORD_W - 1;   // used flag
  localparam int LB     = WORD_W - 2;   // tail flag
  localparam int DHI    = ADDR_W + DATA_W - 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdWord, wdata;
  logic [WORD_W-2:0] predQ, vicQ;
  logic [ADDR_W-1:0] addr, headQ, cmdPtrQ, scanCnt, freeQ, walkQ, loadCnt;
  logic [ADDR_W-1:0] loadNext, newNext;
  logic [DATA_W-1:0] cmdDataQ;
  logic              emptyQ, atHeadQ, cmdLastQ, newLast;

  // address mux
  always_comb begin
    unique case (st.addrSel)
      A_PRED:  addr = cmdPtrQ;
      A_VIC:   addr = atHeadQ ? headQ : predQ[ADDR_W-1:0];
      A_SCAN:  addr = scanCnt;
      A_FREE:  addr = freeQ;
      A_WALK:  addr = walkQ;
      default: addr = loadCnt;
    endcase
  end

  // write word mux
  assign loadNext = cmdLastQ ? '0 : loadCnt + 1'b1;
  assign newLast  = atHeadQ ? emptyQ : predQ[LB];
  assign newNext  = atHeadQ ? (emptyQ ? '0 : headQ) : predQ[ADDR_W-1:0];

  always_comb begin
    unique case (st.wrSel)
      W_LOAD:   wdata = {1'b1, cmdLastQ, cmdDataQ, loadNext};
      W_KILL:   wdata = {1'b0, vicQ};
      W_NEW:    wdata = {1'b1, newLast, cmdDataQ, newNext};
      W_UNLINK: wdata = {1'b1, vicQ[LB], predQ[DHI:ADDR_W], vicQ[ADDR_W-1:0]};
      W_LINK:   wdata = {1'b1, 1'b0, predQ[DHI:ADDR_W], freeQ};
      default:  wdata = '0;
    endcase
  end

  // single-port memory, one cycle read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdWord <= '0;
    end else begin
      if (st.memWr) mem[addr] <= wdata;
      if (st.memRd) rdWord <= mem[addr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0; emptyQ <= 1'b1; atHeadQ <= 1'b0; cmdLastQ <= 1'b0;
      cmdPtrQ <= '0; cmdDataQ <= '0; predQ <= '0; vicQ <= '0;
      scanCnt <= '0; freeQ <= '0; walkQ <= '0; loadCnt <= '0;
    end else begin
      if (st.capCmd) begin
        atHeadQ  <= cmdHead;
        cmdLastQ <= cmdLast;
        cmdPtrQ  <= cmdPtr;
        cmdDataQ <= cmdData;
      end
      if (st.capPred) predQ <= rdWord[WORD_W-2:0];
      if (st.capVic)  vicQ  <= rdWord[WORD_W-2:0];
      if (st.capFree) freeQ <= scanCnt;
      if (st.scanClr) scanCnt <= '0;
      else if (st.scanInc) scanCnt <= scanCnt + 1'b1;
      if (st.walkStart) walkQ <= headQ;
      else if (st.walkStep) walkQ <= rdWord[ADDR_W-1:0];
      if (st.loadStep) begin
        loadCnt <= loadNext;
        if (cmdLastQ) begin
          headQ  <= '0;
          emptyQ <= 1'b0;
        end
      end
      if (st.headPop) begin
        headQ <= vicQ[ADDR_W-1:0];
        if (vicQ[LB]) emptyQ <= 1'b1;
      end
      if (st.headPush) begin
        headQ  <= freeQ;
        emptyQ <= 1'b0;
      end
    end
  end

  assign stat.listEmpty = emptyQ;
  assign stat.rdValid   = rdWord[VB];
  assign stat.rdLast    = rdWord[LB];
  assign stat.scanLast  = (scanCnt == ADDR_W'(DEPTH - 1));

  assign outValid = st.emit;
  assign outLast  = st.emit & rdWord[LB];
  assign outData  = rdWord[DHI:ADDR_W];

endmodule

// File: rtl/ll_ctrl.sv
module ll_ctrl
  import ll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic [1:0] cmdOp,
  input  logic      cmdHead,
  input  llStat_t   stat,
  output llStrobe_t st,
  output logic      busy,
  output logic      done,
  output logic      err
);
  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_PRD, S_PCHK, S_VRD, S_VCHK, S_KILL, S_LINK,
    S_SRD, S_SCHK, S_NEW, S_WRD, S_WEMIT, S_DONE
  } state_t;

  state_t state, nxt;
  llOp_t  opQ;
  logic   atHeadQ, errQ, errSet;

  always_comb begin
    st     = '0;
    nxt    = state;
    errSet = 1'b0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        st.capCmd = 1'b1;
        unique case (llOp_t'(cmdOp))
          OP_LOAD: nxt = S_LOAD;
          OP_WALK: if (stat.listEmpty) nxt = S_DONE;
                   else begin st.walkStart = 1'b1; nxt = S_WRD; end
          OP_DEL:  if (!cmdHead) nxt = S_PRD;
                   else if (stat.listEmpty) begin errSet = 1'b1; nxt = S_DONE; end
                   else nxt = S_VRD;
          default: if (cmdHead) begin st.scanClr = 1'b1; nxt = S_SRD; end
                   else nxt = S_PRD;
        endcase
      end
      S_LOAD: begin
        st.memWr = 1'b1; st.addrSel = A_LOAD; st.wrSel = W_LOAD;
        st.loadStep = 1'b1; nxt = S_DONE;
      end
      S_PRD: begin st.memRd = 1'b1; st.addrSel = A_PRED; nxt = S_PCHK; end
      S_PCHK: begin
        st.capPred = 1'b1;
        if (!stat.rdValid || (opQ == OP_DEL && stat.rdLast)) begin
          errSet = 1'b1; nxt = S_DONE;
        end else if (opQ == OP_DEL) nxt = S_VRD;
        else begin st.scanClr = 1'b1; nxt = S_SRD; end
      end
      S_VRD:  begin st.memRd = 1'b1; st.addrSel = A_VIC; nxt = S_VCHK; end
      S_VCHK: begin st.capVic = 1'b1; nxt = S_KILL; end
      S_KILL: begin
        st.memWr = 1'b1; st.addrSel = A_VIC; st.wrSel = W_KILL;
        st.headPop = atHeadQ;
        nxt = atHeadQ ? S_DONE : S_LINK;
      end
      S_LINK: begin
        st.memWr = 1'b1; st.addrSel = A_PRED;
        st.wrSel = (opQ == OP_DEL) ? W_UNLINK : W_LINK;
        nxt = S_DONE;
      end
      S_SRD:  begin st.memRd = 1'b1; st.addrSel = A_SCAN; nxt = S_SCHK; end
      S_SCHK: begin
        if (!stat.rdValid) begin st.capFree = 1'b1; nxt = S_NEW; end
        else if (stat.scanLast) begin errSet = 1'b1; nxt = S_DONE; end
        else begin st.scanInc = 1'b1; nxt = S_SRD; end
      end
      S_NEW: begin
        st.memWr = 1'b1; st.addrSel = A_FREE; st.wrSel = W_NEW;
        st.headPush = atHeadQ;
        nxt = atHeadQ ? S_DONE : S_LINK;
      end
      S_WRD:   begin st.memRd = 1'b1; st.addrSel = A_WALK; nxt = S_WEMIT; end
      S_WEMIT: begin
        st.emit = 1'b1; st.walkStep = 1'b1;
        nxt = stat.rdLast ? S_DONE : S_WRD;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; opQ <= OP_LOAD; atHeadQ <= 1'b0; errQ <= 1'b0;
    end else begin
      state <= nxt;
      if (st.capCmd) begin
        opQ     <= llOp_t'(cmdOp);
        atHeadQ <= cmdHead;
      end
      if (state == S_IDLE) errQ <= errSet;
      else if (errSet) errQ <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
  assign err  = (state == S_DONE) & errQ;

endmodule

// File: rtl/ll_engine.sv
module ll_engine
  import ll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              cmdHead,
  input  logic              cmdLast,
  input  logic [ADDR_W-1:0] cmdPtr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              outValid,
  output logic              outLast,
  output logic [DATA_W-1:0] outData
);
  llStrobe_t strobe;
  llStat_t   stat;

  ll_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdHead(cmdHead), .stat(stat), .st(strobe),
    .busy(busy), .done(done), .err(err)
  );

  ll_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .st(strobe), .cmdHead(cmdHead),
    .cmdLast(cmdLast), .cmdPtr(cmdPtr), .cmdData(cmdData), .stat(stat),
    .outValid(outValid), .outLast(outLast), .outData(outData)
  );

endmodule

// File: rtl/ll_engine_chk.sv
module ll_engine_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic busy,
  input logic done,
  input logic err,
  input logic outValid,
  input logic outLast
);
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);                                   // R13
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                 // R13
  AST_STREAM_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);                              // R3
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);                           // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!done && !outValid && !err));         // R12
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);                   // R12
endmodule

bind ll_engine ll_engine_chk uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy), .done(done),
  .err(err), .outValid(outValid), .outLast(outLast)
);

// File: tb/ll_engine_test.sv
module ll_engine_test;
  import ll_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic       cmdHead = 1'b0;
  logic       cmdLast = 1'b0;
  logic [2:0] cmdPtr = 3'd0;
  logic [7:0] cmdData = 8'd0;
  logic       busy, done, err, outValid, outLast;
  logic [7:0] outData;

  int errors = 0;
  int checks = 0;
  int gotCnt, gotErr;
  int gotData [16];
  int gotLast [16];
  int expList [16];

  always #2.5 clk = ~clk;   // 200 MHz

  ll_engine uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdHead(cmdHead), .cmdLast(cmdLast), .cmdPtr(cmdPtr), .cmdData(cmdData),
    .busy(busy), .done(done), .err(err), .outValid(outValid),
    .outLast(outLast), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one command for one cycle; returns on the following negedge
  task automatic send(input llOp_t op, input bit hd, input bit lst,
                      input int ptr, input int dat);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdHead = hd; cmdLast = lst;
    cmdPtr = 3'(ptr); cmdData = 8'(dat);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // gather stream words until done; bounded wait acts as watchdog
  task automatic collect();
    int cyc = 0;
    gotCnt = 0; gotErr = 0;
    forever begin
      if (outValid && gotCnt < 16) begin
        gotData[gotCnt] = outData;
        gotLast[gotCnt] = outLast;
        gotCnt++;
      end
      if (done) begin gotErr = err; break; end
      @(negedge clk);
      cyc++;
      if (cyc > 400) begin
        chk(1'b0, "R13", "watchdog expired waiting for done", cyc, 400);
        break;
      end
    end
    @(negedge clk);
    chk(!done && !busy, "R13", "done lasts one cycle then idle", done, 0);
  endtask

  task automatic run(input llOp_t op, input bit hd, input bit lst,
                     input int ptr, input int dat);
    send(op, hd, lst, ptr, dat);
    collect();
  endtask

  task automatic walkCheck(input string req, input int n);
    run(OP_WALK, 0, 0, 0, 0);
    chk(gotCnt == n, req, "walk word count", gotCnt, n);
    chk(gotErr == 0, req, "walk err", gotErr, 0);
    for (int k = 0; k < n && k < gotCnt; k++) begin
      chk(gotData[k] == expList[k], req, $sformatf("word %0d data", k),
          gotData[k], expList[k]);
      chk(gotLast[k] == (k == n - 1), req, $sformatf("word %0d last", k),
          gotLast[k], (k == n - 1));
    end
  endtask

  task automatic expectErr(input string req, input llOp_t op, input bit hd,
                           input int ptr, input int dat);
    run(op, hd, 0, ptr, dat);
    chk(gotErr == 1, req, "refusal err pulse", gotErr, 1);
  endtask

  task automatic expectOk(input string req, input llOp_t op, input bit hd,
                          input int ptr, input int dat);
    run(op, hd, 0, ptr, dat);
    chk(gotErr == 0, req, "command accepted without err", gotErr, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!busy && !done && !err && !outValid, "R1", "outputs after reset",
        {busy, done, err, outValid}, 0);
    walkCheck("R1", 0);
  endtask

  task automatic testLoad();
    run(OP_LOAD, 0, 0, 0, 10);
    run(OP_LOAD, 0, 0, 0, 20);
    run(OP_LOAD, 0, 0, 0, 30);
    run(OP_LOAD, 0, 1, 0, 40);
    expList[0:3] = '{10, 20, 30, 40};
    walkCheck("R2", 4);
  endtask

  task automatic testRemoveMid();
    expectOk("R4", OP_DEL, 0, 1, 0);   // successor of addr1 is addr2 (30)
    expList[0:2] = '{10, 20, 40};
    walkCheck("R4", 3);
  endtask

  task automatic testAddMid();
    expectOk("R8", OP_INS, 0, 0, 55);  // lowest free slot is addr2
    expList[0:3] = '{10, 55, 20, 40};
    walkCheck("R8", 4);
    expectOk("R10", OP_DEL, 0, 2, 0);  // addr2 holds 55, its successor is 20
    expList[0:2] = '{10, 55, 40};
    walkCheck("R10", 3);
  endtask

  task automatic testAddTail();
    expectOk("R8", OP_INS, 0, 3, 66);  // after tail (40 at addr3), lands at addr1
    expList[0:3] = '{10, 55, 40, 66};
    walkCheck("R8", 4);
  endtask

  task automatic testRefusals();
    expectErr("R7", OP_DEL, 0, 1, 0);  // addr1 is the tail
    expectErr("R7", OP_DEL, 0, 5, 0);  // addr5 unused
    expectErr("R8", OP_INS, 0, 6, 9);  // add after unused addr6
    walkCheck("R7", 4);
  endtask

  task automatic testRemoveTail();
    expectOk("R5", OP_DEL, 0, 3, 0);
    expList[0:2] = '{10, 55, 40};
    walkCheck("R5", 3);
  endtask

  task automatic testHeadOps();
    expectOk("R6", OP_DEL, 1, 0, 0);
    expList[0:1] = '{55, 40};
    walkCheck("R6", 2);
    expectOk("R9", OP_INS, 1, 0, 77);
    expList[0:2] = '{77, 55, 40};
    walkCheck("R9", 3);
  endtask

  task automatic testBusyIgnore();
    send(OP_WALK, 0, 0, 0, 0);
    chk(busy == 1, "R12", "busy after accept", busy, 1);
    cmdValid = 1'b1; cmdOp = OP_DEL; cmdHead = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    collect();
    chk(gotCnt == 3 && gotErr == 0, "R12", "walk during ignored cmd", gotCnt, 3);
    expList[0:2] = '{77, 55, 40};
    walkCheck("R12", 3);
  endtask

  task automatic testFull();
    for (int v = 1; v <= 5; v++) expectOk("R11", OP_INS, 1, 0, v);
    expectErr("R11", OP_INS, 1, 0, 200);
    expList[0:7] = '{5, 4, 3, 2, 1, 77, 55, 40};
    walkCheck("R11", 8);
  endtask

  task automatic testDrain();
    for (int k = 0; k < 8; k++) expectOk("R6", OP_DEL, 1, 0, 0);
    walkCheck("R6", 0);
    expectErr("R7", OP_DEL, 1, 0, 0);
    expectOk("R9", OP_INS, 1, 0, 99);
    expList[0] = 99;
    walkCheck("R9", 1);
  endtask

  task automatic testWalkOrder();
    // list order differs from address order here: 99 then new head
    expectOk("R3", OP_INS, 1, 0, 123);
    expList[0:1] = '{123, 99};
    walkCheck("R3", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoad();
    testRemoveMid();
    testAddMid();
    testAddTail();
    testRefusals();
    testRemoveTail();
    testHeadOps();
    testBusyIgnore();
    testFull();
    testDrain();
    testWalkOrder();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule